// File: doc/BRIEF.md
# Prioritized trap interrupt selector

This block holds the pending state of seven interrupt classes, each backed by a 64-bit vector of individual sources. Producers raise and drop single sources with post and clear requests that name a class and a bit index. A clear-all command empties everything. The block keeps one summary bit per class and an any-pending flag.

From the registered state and two processor mode inputs, a hyperprivileged flag and an interrupt-enable flag, combinational logic picks the single interrupt to deliver. It presents that interrupt as a cause code. For software interrupts it also gives a 4-bit level, which is derived from the software vector with a fixed special case for two bit positions. The trap sequencer reads the cause and performs the handler-side clearing through the same clear port.

Top module: `trap_irq_sel`

## Requirements
- R1: While reset is asserted, and after it, every vector and summary bit is zero: `summary_o`=0, `pending_o`=0, `valid_o`=0, `cause_o`=0 (no interrupt), `level_o`=0 and `cls_err_o`=0.
- R2: Class numbers are: 0 trap-level-zero, 1 hyper-tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 software interrupt, 6 resumable error. A post sets bit `post_idx_i` of that class's vector on the clock edge, and `summary_o[class]` is high from the next cycle.
- R3: A clear drops bit `clr_idx_i` of the named class. `summary_o[class]` falls only when that vector has become all zero.
- R4: When a post and a clear name the same class and bit in one cycle, the bit ends up set. A post in the same cycle as a clear-all also survives.
- R5: `clr_all_i` zeroes every vector and summary bit on the next edge.
- R6: `pending_o` is high exactly when any summary bit is high, whatever `hpriv_i` and `ie_i` are.
- R7: With `hpriv_i`=1 and `ie_i`=0 nothing is delivered. With `hpriv_i`=1 and `ie_i`=1 only hyper-tick match and interrupt vector can be delivered, and hyper-tick match comes first.
- R8: With `hpriv_i`=0 the order is: trap-level-zero, hyper-tick match, interrupt vector (any `ie_i`). When `ie_i`=1 these are followed by CPU mondo, device mondo, software interrupt and resumable error. `cause_o` is the class number plus one, with 0 meaning none, and `valid_o` is high exactly when `cause_o` is non-zero.
- R9: When the software class is delivered, `level_o` is 14 if bit 0 or bit 16 of its vector is set. Otherwise it is the highest set bit index among bits 15..1, or 0 if none of those bits is set. For any other cause `level_o` is 0.
- R10: A post or clear naming class 7 changes no state, and `cls_err_o` is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_i | input | 1 | Post request |
| post_cls_i | input | 3 | Class of the post |
| post_idx_i | input | 6 | Bit index of the post |
| clr_i | input | 1 | Clear request |
| clr_cls_i | input | 3 | Class of the clear |
| clr_idx_i | input | 6 | Bit index of the clear |
| clr_all_i | input | 1 | Zero all pending state |
| hpriv_i | input | 1 | Hyperprivileged mode |
| ie_i | input | 1 | Interrupts enabled |
| summary_o | output | 7 | Per-class non-empty bits |
| pending_o | output | 1 | Any class pending |
| valid_o | output | 1 | An interrupt is selected |
| cause_o | output | 3 | Selected cause, 0 when none |
| level_o | output | 4 | Software interrupt level |
| cls_err_o | output | 1 | Out-of-range class seen last cycle |

## Verification
Directed sequences load several classes at once and sweep all four mode combinations. This separates the hyperprivileged order from the normal order, and enable-gated classes from the three that ignore the enable. Software vectors holding bit 0, bit 16, a single mid bit, two mid bits, and only bits above 16 distinguish the special case from the highest-bit search and from the zero level. Two-source clears, same-bit post/clear, clear-all together with a post, and class-7 requests check summary retention, post precedence and the error pulse. A long random phase then compares every output to a behavioural model on every clock.

// File: rtl/trap_irq_pkg.sv
package trap_irq_pkg;
  localparam int NUM_CLS = 7;
  localparam int CLS_W   = 3;
  localparam int VEC_W   = 64;
  localparam int IDX_W   = $clog2(VEC_W);
  localparam int LVL_W   = 4;

  // class numbers double as priority rank outside hyperprivileged mode
  localparam int CLS_TLZ   = 0;
  localparam int CLS_HTICK = 1;
  localparam int CLS_IVEC  = 2;
  localparam int CLS_CPUM  = 3;
  localparam int CLS_DEVM  = 4;
  localparam int CLS_SOFT  = 5;
  localparam int CLS_RERR  = 6;

  typedef enum logic [CLS_W-1:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_TLZ   = 3'd1,
    CAUSE_HTICK = 3'd2,
    CAUSE_IVEC  = 3'd3,
    CAUSE_CPUM  = 3'd4,
    CAUSE_DEVM  = 3'd5,
    CAUSE_SOFT  = 3'd6,
    CAUSE_RERR  = 3'd7
  } cause_e;
endpackage

// File: rtl/irq_class_bank.sv
module irq_class_bank #(
  parameter int VEC_W = 64,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             unset_i,
  input  logic [IDX_W-1:0] unset_idx_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             active_o
);
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             active_q;

  // order matters: clear-all, then clear, then post (post wins)
  always_comb begin
    vec_d = clr_all_i ? '0 : vec_q;
    if (unset_i) vec_d[unset_idx_i] = 1'b0;
    if (set_i)   vec_d[set_idx_i]   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q    <= '0;
      active_q <= 1'b0;
    end else begin
      vec_q    <= vec_d;
      active_q <= |vec_d;
    end
  end

  assign vec_o    = vec_q;
  assign active_o = active_q;

  a_r2_post_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (vec_q[$past(set_idx_i)] && active_o));

  a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unset_i && !(set_i && set_idx_i == unset_idx_i)) |=> !vec_q[$past(unset_idx_i)]);

  a_r3_summary_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !clr_all_i && !set_i && unset_i && ((vec_q & ~(VEC_W'(1) << unset_idx_i)) != '0))
    |=> active_o);

  a_r5_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && !set_i) |=> (vec_q == '0 && !active_o));
endmodule

// File: rtl/irq_soft_level.sv
module irq_soft_level #(
  parameter int VEC_W = 64,
  parameter int LVL_W = 4,
  parameter int ALT_BIT = 16,
  parameter int FORCED_LVL = 14
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic [LVL_W-1:0] level_o
);
  localparam int TOP_BIT = (1 << LVL_W) - 1;

  always_comb begin
    level_o = '0;
    for (int i = 1; i <= TOP_BIT; i++) begin
      if (vec_i[i]) level_o = LVL_W'(i);
    end
    if (vec_i[0] || vec_i[ALT_BIT]) level_o = LVL_W'(FORCED_LVL);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import trap_irq_pkg::*;
#(
  parameter int N = NUM_CLS,
  parameter int LW = LVL_W
) (
  input  logic [N-1:0]  pend_i,
  input  logic          hpriv_i,
  input  logic          ie_i,
  input  logic [LW-1:0] soft_lvl_i,
  output logic          valid_o,
  output cause_e        cause_o,
  output logic [LW-1:0] level_o
);
  localparam logic [N-1:0] HPRIV_MASK  = N'((1 << CLS_HTICK) | (1 << CLS_IVEC));
  localparam logic [N-1:0] ALWAYS_MASK = N'((1 << CLS_TLZ) | (1 << CLS_HTICK) | (1 << CLS_IVEC));

  logic [N-1:0] elig_mask, elig;

  always_comb begin
    if (hpriv_i) elig_mask = ie_i ? HPRIV_MASK : '0;
    else         elig_mask = ie_i ? '1 : ALWAYS_MASK;
    elig = pend_i & elig_mask;
  end

  // lowest eligible class number wins
  always_comb begin
    cause_o = CAUSE_NONE;
    for (int c = N - 1; c >= 0; c--) begin
      if (elig[c]) cause_o = cause_e'(c + 1);
    end
    valid_o = (cause_o != CAUSE_NONE);
    level_o = (cause_o == CAUSE_SOFT) ? soft_lvl_i : '0;
  end
endmodule

// File: rtl/trap_irq_sel.sv
module trap_irq_sel
  import trap_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               post_i,
  input  logic [CLS_W-1:0]   post_cls_i,
  input  logic [IDX_W-1:0]   post_idx_i,
  input  logic               clr_i,
  input  logic [CLS_W-1:0]   clr_cls_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  input  logic               clr_all_i,
  input  logic               hpriv_i,
  input  logic               ie_i,
  output logic [NUM_CLS-1:0] summary_o,
  output logic               pending_o,
  output logic               valid_o,
  output logic [CLS_W-1:0]   cause_o,
  output logic [LVL_W-1:0]   level_o,
  output logic               cls_err_o
);
  logic [VEC_W-1:0] vec [NUM_CLS];
  logic             post_bad, clr_bad, err_q;
  logic [LVL_W-1:0] soft_lvl;
  cause_e           cause;

  assign post_bad = post_i && (int'(post_cls_i) >= NUM_CLS);
  assign clr_bad  = clr_i  && (int'(clr_cls_i)  >= NUM_CLS);

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    irq_class_bank #(.VEC_W(VEC_W)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_all_i   (clr_all_i),
      .set_i       (post_i && post_cls_i == CLS_W'(c)),
      .set_idx_i   (post_idx_i),
      .unset_i     (clr_i && clr_cls_i == CLS_W'(c)),
      .unset_idx_i (clr_idx_i),
      .vec_o       (vec[c]),
      .active_o    (summary_o[c])
    );
  end

  irq_soft_level #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_soft (
    .vec_i   (vec[CLS_SOFT]),
    .level_o (soft_lvl)
  );

  irq_prio_pick #(.N(NUM_CLS), .LW(LVL_W)) u_pick (
    .pend_i     (summary_o),
    .hpriv_i    (hpriv_i),
    .ie_i       (ie_i),
    .soft_lvl_i (soft_lvl),
    .valid_o    (valid_o),
    .cause_o    (cause),
    .level_o    (level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= post_bad || clr_bad;
  end

  assign cause_o   = cause;
  assign pending_o = |summary_o;
  assign cls_err_o = err_q;

  a_r7_hpriv_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpriv_i && !ie_i) |-> !valid_o);

  a_r7_hpriv_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpriv_i && ie_i && summary_o[CLS_HTICK]) |-> cause_o == CAUSE_HTICK);

  a_r8_tlz_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hpriv_i && summary_o[CLS_TLZ]) |-> cause_o == CAUSE_TLZ);

  a_r9_level_only_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != CAUSE_SOFT) |-> level_o == '0);

  a_r10_bad_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_bad && !clr_i && !clr_all_i) |=> (cls_err_o && summary_o == $past(summary_o)));
endmodule

// File: tb/trap_irq_sel_bench.sv
module trap_irq_sel_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       post = 0, clr = 0, clr_all = 0, hpriv = 0, ie = 0;
  logic [2:0] post_cls = 0, clr_cls = 0;
  logic [5:0] post_idx = 0, clr_idx = 0;
  logic [6:0] summary;
  logic       pending, valid, cls_err;
  logic [2:0] cause;
  logic [3:0] level;

  int checks = 0, fails = 0;
  logic [63:0] mv [7];
  bit          merr = 0;

  always #2.5 clk = ~clk;

  trap_irq_sel u_trap_irq_sel (
    .clk_i(clk), .rst_ni(rst_n),
    .post_i(post), .post_cls_i(post_cls), .post_idx_i(post_idx),
    .clr_i(clr), .clr_cls_i(clr_cls), .clr_idx_i(clr_idx),
    .clr_all_i(clr_all), .hpriv_i(hpriv), .ie_i(ie),
    .summary_o(summary), .pending_o(pending), .valid_o(valid),
    .cause_o(cause), .level_o(level), .cls_err_o(cls_err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int soft_level(logic [63:0] v);
    if (v[0] || v[16]) return 14;
    for (int i = 15; i >= 1; i--) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int exp_cause();
    if (hpriv) begin
      if (ie && mv[1] != 0) return 2;
      if (ie && mv[2] != 0) return 3;
      return 0;
    end
    if (mv[0] != 0) return 1;
    if (mv[1] != 0) return 2;
    if (mv[2] != 0) return 3;
    if (!ie) return 0;
    if (mv[3] != 0) return 4;
    if (mv[4] != 0) return 5;
    if (mv[5] != 0) return 6;
    if (mv[6] != 0) return 7;
    return 0;
  endfunction

  task automatic compare_all();
    int s = 0;
    int c = exp_cause();
    for (int k = 0; k < 7; k++) if (mv[k] != 0) s |= (1 << k);
    chk("R2/R3 summary", int'(summary), s);
    chk("R6 pending", int'(pending), int'(s != 0));
    chk(hpriv ? "R7 cause" : "R8 cause", int'(cause), c);
    chk("R8 valid", int'(valid), int'(c != 0));
    chk("R9 level", int'(level), (c == 6) ? soft_level(mv[5]) : 0);
    chk("R10 err", int'(cls_err), int'(merr));
  endtask

  // one clock: model takes the inputs held across the edge, then outputs are compared
  task automatic step();
    @(posedge clk);
    merr = (post && post_cls == 7) || (clr && clr_cls == 7);
    if (clr_all) for (int k = 0; k < 7; k++) mv[k] = '0;
    if (clr && clr_cls != 7) mv[clr_cls][clr_idx] = 1'b0;
    if (post && post_cls != 7) mv[post_cls][post_idx] = 1'b1;
    #1;
    compare_all();
    post = 0; clr = 0; clr_all = 0;
  endtask

  task automatic do_post(int c, int i);
    post = 1; post_cls = 3'(c); post_idx = 6'(i); step();
  endtask

  task automatic do_clr(int c, int i);
    clr = 1; clr_cls = 3'(c); clr_idx = 6'(i); step();
  endtask

  task automatic sweep_modes();
    for (int m = 0; m < 4; m++) begin
      hpriv = m[1]; ie = m[0]; #1;
      compare_all();
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 7; k++) mv[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 summary", int'(summary), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 cause", int'(cause), 0);
    chk("R1 err", int'(cls_err), 0);
    rst_n = 1;
    step();

    // R8: stack classes from lowest priority upward, sweeping modes each time
    for (int c = 6; c >= 0; c--) begin
      do_post(c, 10 + c);
      sweep_modes();
    end
    // R7: remove tlz, hyper-tick, then vector, checking modes each time
    do_clr(0, 10); sweep_modes();
    do_clr(1, 11); sweep_modes();
    do_clr(2, 12); sweep_modes();
    do_clr(3, 13); do_clr(4, 14); do_clr(6, 16);
    hpriv = 0; ie = 1;

    // R9: software level patterns
    do_clr(5, 15);
    do_post(5, 9);  chk("R9 mid bit", int'(level), 9);
    do_post(5, 3);  chk("R9 highest of two", int'(level), 9);
    do_post(5, 12); chk("R9 highest of three", int'(level), 12);
    do_post(5, 16); chk("R9 bit16 forces", int'(level), 14);
    do_clr(5, 16);  chk("R9 back to search", int'(level), 12);
    do_post(5, 0);  chk("R9 bit0 forces", int'(level), 14);
    clr_all = 1; step();
    do_post(5, 40); chk("R9 high only", int'(level), 0);
    chk("R9 still soft", int'(cause), 6);

    // R3: summary holds while another source remains
    do_post(5, 41);
    do_clr(5, 40); chk("R3 summary kept", int'(summary[5]), 1);
    do_clr(5, 41); chk("R3 summary dropped", int'(summary[5]), 0);

    // R4: post and clear same bit
    post = 1; post_cls = 3; post_idx = 7; clr = 1; clr_cls = 3; clr_idx = 7; step();
    chk("R4 post beats clear", int'(summary[3]), 1);
    post = 1; post_cls = 4; post_idx = 2; clr_all = 1; step();
    chk("R4 post beats clear-all", int'(summary), 7'h10);

    // R5: clear-all
    do_post(0, 63); do_post(6, 0);
    clr_all = 1; step();
    chk("R5 cleared", int'(summary), 0);

    // R10: bad class
    do_post(2, 5);
    do_post(7, 5);  chk("R10 err pulse", int'(cls_err), 1);
    step();         chk("R10 err one cycle", int'(cls_err), 0);
    do_clr(7, 5);   chk("R10 bad clear ignored", int'(summary), 7'h04);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      post     = ($urandom_range(0, 2) != 0);
      post_cls = 3'($urandom_range(0, 7));
      post_idx = 6'($urandom_range(0, 3) == 0 ? $urandom_range(0, 63) : $urandom_range(0, 17));
      clr      = ($urandom_range(0, 1) != 0);
      clr_cls  = 3'($urandom_range(0, 7));
      clr_idx  = 6'($urandom_range(0, 3) == 0 ? $urandom_range(0, 63) : $urandom_range(0, 17));
      clr_all  = ($urandom_range(0, 40) == 0);
      hpriv    = 1'($urandom_range(0, 1));
      ie       = 1'($urandom_range(0, 1));
      step();
    end
    finish_run();
  end
endmodule